// File: doc/BRIEF.md
# SPI Register-Access Target

This block is a four-wire SPI target that gives an external host read and write access to a register file held elsewhere on the chip. The host pulls chip select low and clocks in a command byte. The top bit of that byte picks the direction and the lower seven bits give a starting register. Data bytes then follow, as many as the host wants. In a write, each complete byte is sent to the register file with a one-cycle strobe. In a read, register contents are shifted back out on the serial output. In both cases the register index advances after every data byte.

The serial pins are not used as a clock. Chip select, serial clock and serial input are each brought into the system clock domain through a synchronizer, and edges are detected there. The system clock must be well over twice the serial clock rate. At 250 MHz against a 10 MHz serial clock there are about 25 system cycles per serial bit. Serial data is captured on rising SCLK edges and launched on falling edges, with the clock idling low. The register file is expected to return read data combinationally from the address it is given.

Top module: `spi_regif_top`

## Requirements
- R1: `spi_sdo` is high-impedance whenever `spi_cs_n` is high, and this includes the reset state. `reg_we` stays low while in reset and while deselected, unless a byte finished on the final edge (R10).
- R2: The first byte after `spi_cs_n` falls is the command, received MSB first. Bit 7 set to 1 means read and 0 means write. Bits 6:0 hold the starting register address.
- R3: In a write, each complete data byte produces exactly one single-cycle `reg_we` pulse. During that pulse `reg_wdata` holds the byte as received MSB first, and for the first byte `reg_addr` equals the command address.
- R4: Within a write burst, each further byte goes to the next address. The address is 7 bits wide, so after 127 it wraps to 0.
- R5: In a read, the byte at the command address is presented on `spi_sdo` MSB first. Each bit changes after a falling SCLK edge, and the first bit is valid before the 9th rising edge of the transaction.
- R6: Within a read burst, successive bytes come from consecutive addresses, wrapping from 127 to 0.
- R7: When `spi_cs_n` rises partway through a data byte, those bits are discarded and produce no write.
- R8: A rise of `spi_cs_n` at any point clears the bit count and state. A command byte left incomplete has no effect on the next transaction, which starts a fresh command.
- R9: A read transaction never pulses `reg_we`.
- R10: A rising SCLK edge that arrives together with the rise of `spi_cs_n` still completes its byte. If that byte is a write data byte, it is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host, high-impedance when deselected |
| reg_addr | output | 7 | Register file address |
| reg_wdata | output | 8 | Register file write data |
| reg_we | output | 1 | Register file write strobe, one cycle |
| reg_rdata | input | 8 | Register file read data for `reg_addr` |

## Verification
The case most likely to go wrong is the last rising SCLK edge of a write byte being seen in the same system cycle as the release of chip select. In that cycle the byte has to be committed while the state machine also returns to idle. The bench provokes this by driving both pins high at the same instant, so that both pass through synchronizers of equal depth and arrive together. It then judges the result from the write strobes it sees against its expected-write queue, and from a later read-back of the affected registers.

// File: rtl/spi_regif_pkg.sv
`timescale 1ns/1ps
package spi_regif_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int BIT_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_WR   = 2'd2,
    ST_RD   = 2'd3
  } spi_state_e;
endpackage

// File: rtl/spi_regif_sync.sv
`timescale 1ns/1ps
module spi_regif_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= RST_VAL;
          else        stg_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= RST_VAL;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_regif_edge.sv
`timescale 1ns/1ps
module spi_regif_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic cs_n_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_rise
);
  logic sclk_d_q, cs_n_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cs_n_d_q <= 1'b1;
    end else begin
      sclk_d_q <= sclk_s;
      cs_n_d_q <= cs_n_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d_q;
  assign sclk_fall = ~sclk_s & sclk_d_q;
  assign cs_fall   = ~cs_n_s & cs_n_d_q;
  assign cs_rise   = cs_n_s & ~cs_n_d_q;
endmodule

// File: rtl/spi_regif_ctrl.sv
`timescale 1ns/1ps
module spi_regif_ctrl
  import spi_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              sdo_bit
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  spi_state_e        state_q, state_d;
  logic [BIT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [DATA_W-1:0] rx_q, rx_d, rx_next;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              we_q, we_d;
  logic              fetch_q, fetch_d;
  logic              sdo_q, sdo_d;
  logic              active;

  assign active  = (state_q != ST_IDLE);
  assign rx_next = {rx_q[DATA_W-2:0], sdi_s};

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    wdata_d  = wdata_q;
    addr_d   = addr_q;
    sdo_d    = sdo_q;
    we_d     = 1'b0;
    fetch_d  = 1'b0;

    if (we_q)    addr_d = addr_q + 1'b1;
    if (fetch_q) tx_d   = reg_rdata;

    if (sclk_rise && active) begin
      rx_d     = rx_next;
      bitcnt_d = bitcnt_q + 1'b1;
      if (bitcnt_q == LAST_BIT) begin
        unique case (state_q)
          ST_CMD: begin
            addr_d = rx_next[ADDR_W-1:0];
            if (rx_next[DATA_W-1]) begin
              state_d = ST_RD;
              fetch_d = 1'b1;
            end else begin
              state_d = ST_WR;
            end
          end
          ST_WR: begin
            we_d    = 1'b1;
            wdata_d = rx_next;
          end
          ST_RD: begin
            addr_d  = addr_q + 1'b1;
            fetch_d = 1'b1;
          end
          default: ;
        endcase
      end
    end

    if (sclk_fall && active) begin
      sdo_d = tx_q[DATA_W-1];
      tx_d  = {tx_q[DATA_W-2:0], 1'b0};
    end

    if (cs_fall) begin
      state_d  = ST_CMD;
      bitcnt_d = '0;
      sdo_d    = 1'b0;
      tx_d     = '0;
    end

    if (cs_rise) begin
      state_d  = ST_IDLE;
      bitcnt_d = '0;
      fetch_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      wdata_q  <= '0;
      addr_q   <= '0;
      sdo_q    <= 1'b0;
      we_q     <= 1'b0;
      fetch_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      wdata_q  <= wdata_d;
      addr_q   <= addr_d;
      sdo_q    <= sdo_d;
      we_q     <= we_d;
      fetch_q  <= fetch_d;
    end
  end

  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;
  assign sdo_bit   = sdo_q;

  // R3
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> (addr_q == $past(addr_q) + 1'b1));

  // R8
  cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (state_q == ST_IDLE && bitcnt_q == '0));

  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_fall || cs_fall) |=> $stable(sdo_q));

  // R9
  rd_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD) |-> !we_q);
endmodule

// File: rtl/spi_regif_top.sv
`timescale 1ns/1ps
module spi_regif_top
  import spi_regif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;
  logic       cs_n_s, sclk_s, sdi_s;
  logic       sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic       sdo_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  spi_regif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n_s), .async_i(spi_cs_n), .sync_o(cs_n_s));
  spi_regif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n_s), .async_i(spi_sclk), .sync_o(sclk_s));
  spi_regif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n_s), .async_i(spi_sdi), .sync_o(sdi_s));

  spi_regif_edge u_edge (
    .clk(clk), .rst_n(rst_n_s), .sclk_s(sclk_s), .cs_n_s(cs_n_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise));

  spi_regif_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sdi_s(sdi_s),
    .reg_rdata(reg_rdata), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .sdo_bit(sdo_bit));

  assign spi_sdo = spi_cs_n ? 1'bz : sdo_bit;

  // R1
  no_we_in_reset_chk: assert property (@(posedge clk)
    !rst_n_s |-> !reg_we);
endmodule

// File: tb/tb_spi_regif_top.sv
`timescale 1ns/1ps
module tb_spi_regif_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       spi_cs_n, spi_sclk, spi_sdi;
  wire        spi_sdo;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       reg_we;

  logic [7:0] mem     [128];
  logic [7:0] exp_mem [128];
  typedef struct packed { logic [6:0] a; logic [7:0] d; } wr_t;
  wr_t exp_q[$];

  int n_chk = 0, n_fail = 0;
  bit run_mon = 0;

  always #2 clk = ~clk;

  spi_regif_top dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle reference comparison: write strobes against the expected queue,
  // and output release while deselected.
  always @(negedge clk) begin
    if (run_mon) begin
      if (spi_cs_n === 1'b1 && spi_sdo !== 1'bz)
        check(0, "R1 sdo not released", int'(spi_sdo), 0);
      if (reg_we) begin
        if (exp_q.size() == 0) begin
          check(0, "R7 R9 unexpected write", {reg_addr, reg_wdata}, 0);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          check(reg_addr == e.a && reg_wdata == e.d, "R3 R4 write",
                {reg_addr, reg_wdata}, {e.a, e.d});
        end
      end
    end
  end

  task automatic send_bits(input logic [7:0] b, input int nbits, input bit merge,
                           output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      spi_sclk = 1'b0;
      spi_sdi  = b[7-i];
      #50;
      got = {got[6:0], spi_sdo};
      spi_sclk = 1'b1;
      if (merge && i == nbits - 1) spi_cs_n = 1'b1;
      #50;
    end
  endtask

  // rw: 1 read, 0 write. partial: extra bits after the data bytes.
  // merge: last rising edge coincides with chip select release.
  task automatic xact(input bit rw, input logic [6:0] addr, input int nbytes,
                      input int partial, input bit merge, input string req);
    logic [7:0] got;
    logic [6:0] a;
    bit last_merge;
    a = addr;
    spi_cs_n = 1'b0;
    #100;
    send_bits({rw, addr}, 8, merge && nbytes == 0 && partial == 0, got);
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] d;
      d = 8'(a * 7 + 8'h5B + k);
      last_merge = merge && (k == nbytes - 1) && partial == 0;
      if (!rw) begin
        exp_q.push_back('{a: a, d: d});
        exp_mem[a] = d;
      end
      send_bits(d, 8, last_merge, got);
      if (rw) check(got == exp_mem[a], req, got, exp_mem[a]);
      a = a + 1'b1;
    end
    if (partial > 0) send_bits(8'hC3, partial, merge, got);
    spi_sclk = 1'b0;
    #50;
    spi_cs_n = 1'b1;
    #200;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i]     = 8'(i * 3 + 1);
      exp_mem[i] = 8'(i * 3 + 1);
    end
    rst_n = 1'b0; spi_cs_n = 1'b1; spi_sclk = 1'b0; spi_sdi = 1'b0;
    #21;
    // R1 reset state
    check(spi_sdo === 1'bz, "R1 reset sdo", int'(spi_sdo), 0);
    check(reg_we === 1'b0, "R1 reset we", int'(reg_we), 0);
    rst_n = 1'b1;
    #40;
    run_mon = 1;
    // R1 still released after reset
    check(spi_sdo === 1'bz, "R1 idle sdo", int'(spi_sdo), 0);

    xact(0, 7'h05, 1, 0, 0, "R2 R3 single write");
    xact(0, 7'h10, 4, 0, 0, "R4 burst write");
    xact(1, 7'h05, 1, 0, 0, "R5 single read");
    xact(1, 7'h10, 4, 0, 0, "R6 burst read");
    xact(1, 7'h40, 3, 0, 0, "R6 read untouched");
    xact(0, 7'h7E, 3, 0, 0, "R4 write wrap");
    xact(1, 7'h7F, 2, 0, 0, "R6 read wrap");
    // R7 partial data byte discarded
    xact(0, 7'h20, 1, 5, 0, "R7 partial");
    xact(1, 7'h20, 2, 0, 0, "R7 readback");
    // R8 incomplete command, then a fresh transaction
    spi_cs_n = 1'b0; #100;
    begin
      logic [7:0] g;
      send_bits(8'h7F, 3, 0, g);
    end
    spi_sclk = 1'b0; #50; spi_cs_n = 1'b1; #200;
    xact(0, 7'h22, 1, 0, 0, "R8 fresh command");
    xact(1, 7'h21, 2, 0, 0, "R8 readback");
    // R10 final rising edge with chip select release
    xact(0, 7'h30, 2, 0, 1, "R10 merged end");
    xact(1, 7'h30, 2, 0, 0, "R10 readback");
    // R9 reads produced no writes: every expected write consumed, none extra
    #200;
    check(exp_q.size() == 0, "R3 R9 write count", exp_q.size(), 0);
    run_mon = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule